// File: doc/BRIEF.md
# Programmable Peripheral Clock Generator

This block derives one peripheral clock from a small set of reference clocks, all seen inside a single fast system clock domain as one-cycle tick strobes (one tick per reference period). The path runs from a source picker through two cascaded integer divide stages to an enable gate. Software sets the picker, the two divide fields and the stop bit through a one-word write port. The block drives the resulting clock level and a read-back of the total divide ratio currently programmed. A parameter chooses the variant: the double divider, a one-field lookup divider (1/2 or 2/4), or a fixed crystal source with only the gate.

Any change to the source, the ratio or the stop bit is held in a shadow register. It moves into the active path only where one output period ends, which is always inside a low phase. The output therefore never carries a shortened pulse. An invalid divide field yields a zero ratio, raises a status flag and holds the output low.

Top module: `pclk_gen`

## Requirements
- R1: After reset the output is low, the stop bit is set so no edge appears until software clears it, the read-back ratio is 1 and the status flag is low.
- R2: Writes decode the offset: 0x00 holds the source field in data bits [1:0]; 0x04 holds stage A in bits [5:3] and stage B in bits [2:0]; 0x14 holds the stop bit in bit 0. Writes to any other offset (0x08, 0x0C, 0x10 among them) change neither the read-back nor the output.
- R3: With both divide fields between 1 and 6, the read-back equals their product from the cycle after the write.
- R4: A divide field of 0 or 7 makes the read-back 0 and sets the status flag. The output then stays low once the running period has ended.
- R5: For a total ratio N of 2 or more, one output period lasts N selected ticks, with floor(N/2) ticks high and the rest low. For N = 1 the output is high for one tick and low for one tick.
- R6: Only ticks of the selected reference advance the output, and the output changes only in a cycle that carries a tick.
- R7: Setting the stop bit lets the current high phase finish at full length, then keeps the output low. Clearing it restarts the clock on the next selected tick.
- R8: A new divide or source setting written during a period takes effect only after that period has completed with the old setting.
- R9: In the 2/4 lookup variant, stage A value 0 reads back as 2, value 1 reads back as 4, and any other value reads back as 0 with the status flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | NUM_REF | One-cycle strobe per reference clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the register written |
| wr_data | input | DATA_W | Write data |
| clk_out | output | 1 | Gated, divided clock level |
| ratio_rb | output | RATIO_W | Programmed total divide ratio, 0 when invalid |
| ratio_bad | output | 1 | Set while the programmed ratio is invalid |

## Verification
The bench builds two instances on the same write bus. The first uses the default double-divider variant with four references ticking every 2, 3, 4 and 5 system cycles. That makes source selection visible as a difference in period length, and covers ratios from 1 to 36, both odd and even. The second uses the 2/4 lookup variant, which makes the table decoding and its invalid codes reachable through the read-back port.

// File: rtl/pclk_gen_pkg.sv
package pclk_gen_pkg;

   // Divider variant selected per instance
   typedef enum logic [1:0] {
      PG_DOUBLE  = 2'd0,   // two cascaded 1..6 stages
      PG_TBL_1_2 = 2'd1,   // one field: 0 -> 1, 1 -> 2
      PG_TBL_2_4 = 2'd2,   // one field: 0 -> 2, 1 -> 4
      PG_FIXED   = 2'd3    // crystal source, gate only
   } pg_variant_e;

endpackage

// File: rtl/pg_regs.sv
module pg_regs #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int SEL_W     = 2,
   parameter int DIV_FW    = 3,
   parameter int SEL_OFS   = 'h00,
   parameter int DIV_OFS   = 'h04,
   parameter int GATE_OFS  = 'h14,
   parameter int SEL_LSB   = 0,
   parameter int DIV_A_LSB = 3,
   parameter int DIV_B_LSB = 0,
   parameter int GATE_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEL_W-1:0]  sel_q,
   output logic [DIV_FW-1:0] div_a_q,
   output logic [DIV_FW-1:0] div_b_q,
   output logic              gate_q
);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DIV_OFS);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(GATE_OFS);

   logic unused_bits;
   assign unused_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= '0;
         div_a_q <= DIV_FW'(1);
         div_b_q <= DIV_FW'(1);
         gate_q  <= 1'b1;
      end else if (wr_en) begin
         if (wr_addr == A_SEL)
            sel_q <= wr_data[SEL_LSB +: SEL_W];
         if (wr_addr == A_DIV) begin
            div_a_q <= wr_data[DIV_A_LSB +: DIV_FW];
            div_b_q <= wr_data[DIV_B_LSB +: DIV_FW];
         end
         if (wr_addr == A_GATE)
            gate_q <= wr_data[GATE_BIT];
      end
   end
endmodule

// File: rtl/pg_ratio.sv
module pg_ratio
   import pclk_gen_pkg::*;
#(
   parameter pg_variant_e VARIANT = PG_DOUBLE,
   parameter int DIV_FW  = 3,
   parameter int DIV_MAX = 6,
   parameter int RATIO_W = 6
) (
   input  logic [DIV_FW-1:0]  div_a,
   input  logic [DIV_FW-1:0]  div_b,
   output logic [RATIO_W-1:0] ratio
);
   generate
      if (VARIANT == PG_DOUBLE) begin : g_double
         logic [RATIO_W-1:0] ra, rb;
         always_comb begin
            ra = (div_a != '0 && div_a <= DIV_FW'(DIV_MAX)) ? RATIO_W'(div_a) : '0;
            rb = (div_b != '0 && div_b <= DIV_FW'(DIV_MAX)) ? RATIO_W'(div_b) : '0;
            ratio = ra * rb;
         end
      end else if (VARIANT == PG_FIXED) begin : g_fixed
         logic unused_fields;
         assign unused_fields = ^{div_a, div_b};
         assign ratio = RATIO_W'(1);
      end else begin : g_table
         localparam int R_LO = (VARIANT == PG_TBL_1_2) ? 1 : 2;
         localparam int R_HI = (VARIANT == PG_TBL_1_2) ? 2 : 4;
         logic unused_stage_b;
         assign unused_stage_b = ^div_b;
         always_comb begin
            if (div_a == '0)
               ratio = RATIO_W'(R_LO);
            else if (div_a == DIV_FW'(1))
               ratio = RATIO_W'(R_HI);
            else
               ratio = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/pg_phase.sv
module pg_phase #(
   parameter int NUM_REF = 4,
   parameter int SEL_W   = 2,
   parameter int RATIO_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REF-1:0] ref_tick,
   input  logic [SEL_W-1:0]   sh_sel,
   input  logic [RATIO_W-1:0] sh_ratio,
   input  logic               sh_gate,
   output logic               clk_out
);
   logic [SEL_W-1:0]   act_sel_q;
   logic [RATIO_W-1:0] act_per_q, act_hi_q, cnt_q;
   logic               act_run_q, out_q;

   logic [RATIO_W-1:0] sh_per, sh_hi;
   logic               sh_run, tick_act, tick_sh, load;

   // ratio 1 cannot be expressed with tick enables: fastest form is 1 high, 1 low
   always_comb begin
      sh_per   = (sh_ratio == RATIO_W'(1)) ? RATIO_W'(2) : sh_ratio;
      sh_hi    = sh_per >> 1;
      sh_run   = !sh_gate && (sh_ratio != '0);
      tick_act = ref_tick[act_sel_q];
      tick_sh  = ref_tick[sh_sel];
      // idle path reloads on a tick of the newly chosen source;
      // running path reloads only on the last (low) tick of a period
      load     = act_run_q ? (tick_act && (cnt_q == act_per_q - RATIO_W'(1)))
                           : tick_sh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_sel_q <= '0;
         act_per_q <= '0;
         act_hi_q  <= '0;
         act_run_q <= 1'b0;
         cnt_q     <= '0;
         out_q     <= 1'b0;
      end else if (load) begin
         act_sel_q <= sh_sel;
         act_per_q <= sh_per;
         act_hi_q  <= sh_hi;
         act_run_q <= sh_run;
         cnt_q     <= '0;
         out_q     <= sh_run;
      end else if (act_run_q && tick_act) begin
         cnt_q <= cnt_q + RATIO_W'(1);
         out_q <= (cnt_q + RATIO_W'(1)) < act_hi_q;
      end
   end

   assign clk_out = out_q;
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
   import pclk_gen_pkg::*;
#(
   parameter pg_variant_e VARIANT = PG_DOUBLE,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_REF   = 4,
   parameter int XTAL_IDX  = 3,
   parameter int DIV_FW    = 3,
   parameter int DIV_MAX   = 6,
   parameter int SEL_OFS   = 'h00,
   parameter int DIV_OFS   = 'h04,
   parameter int GATE_OFS  = 'h14,
   parameter int SEL_LSB   = 0,
   parameter int DIV_A_LSB = 3,
   parameter int DIV_B_LSB = 0,
   parameter int GATE_BIT  = 0,
   localparam int SEL_W    = $clog2(NUM_REF),
   localparam int RATIO_W  = $clog2(DIV_MAX * DIV_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REF-1:0] ref_tick,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               clk_out,
   output logic [RATIO_W-1:0] ratio_rb,
   output logic               ratio_bad
);
   localparam int HAS_DIV = (VARIANT != PG_FIXED) ? 1 : 0;

   // elaboration-time parameter checks
   generate
      if (NUM_REF < 2)
         $error("pclk_gen: NUM_REF must be at least 2");
      if (XTAL_IDX >= NUM_REF)
         $error("pclk_gen: XTAL_IDX out of range");
      if (DIV_MAX < 1 || DIV_MAX >= (1 << DIV_FW))
         $error("pclk_gen: DIV_MAX must fit below the all-ones field code");
      if (DIV_OFS != 'h04 && DIV_OFS != 'h08 && DIV_OFS != 'h0C)
         $error("pclk_gen: DIV_OFS must name one of the three divider registers");
      if (SEL_LSB + SEL_W > DATA_W || DIV_A_LSB + DIV_FW > DATA_W ||
          DIV_B_LSB + DIV_FW > DATA_W || GATE_BIT >= DATA_W)
         $error("pclk_gen: field position beyond data width");
   endgenerate

   logic [SEL_W-1:0]   sel_q, sel_eff;
   logic [DIV_FW-1:0]  div_a_q, div_b_q;
   logic               gate_q;
   logic [RATIO_W-1:0] ratio_w;

   pg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .DIV_FW(DIV_FW),
      .SEL_OFS(SEL_OFS), .DIV_OFS(DIV_OFS), .GATE_OFS(GATE_OFS),
      .SEL_LSB(SEL_LSB), .DIV_A_LSB(DIV_A_LSB), .DIV_B_LSB(DIV_B_LSB),
      .GATE_BIT(GATE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sel_q(sel_q), .div_a_q(div_a_q),
      .div_b_q(div_b_q), .gate_q(gate_q)
   );

   pg_ratio #(
      .VARIANT(VARIANT), .DIV_FW(DIV_FW), .DIV_MAX(DIV_MAX), .RATIO_W(RATIO_W)
   ) u_ratio (
      .div_a(div_a_q), .div_b(div_b_q), .ratio(ratio_w)
   );

   generate
      if (VARIANT == PG_FIXED) begin : g_src_fixed
         logic unused_sel;
         assign unused_sel = ^sel_q;
         assign sel_eff = SEL_W'(XTAL_IDX);
      end else begin : g_src_mux
         assign sel_eff = sel_q;
      end
   endgenerate

   pg_phase #(
      .NUM_REF(NUM_REF), .SEL_W(SEL_W), .RATIO_W(RATIO_W)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sh_sel(sel_eff),
      .sh_ratio(ratio_w), .sh_gate(gate_q), .clk_out(clk_out)
   );

   assign ratio_rb  = ratio_w;
   assign ratio_bad = (ratio_w == '0);
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_REF   = 4,
   parameter int RATIO_W   = 6,
   parameter int DIV_FW    = 3,
   parameter int DIV_MAX   = 6,
   parameter int DIV_OFS   = 'h04,
   parameter int DIV_A_LSB = 3,
   parameter int HAS_DIV   = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REF-1:0] ref_tick,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               clk_out,
   input logic [RATIO_W-1:0] ratio_rb,
   input logic               ratio_bad,
   input logic               sh_gate
);
   generate
      if (HAS_DIV != 0) begin : g_div_chk
         // R4
         invalid_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(DIV_OFS) &&
             wr_data[DIV_A_LSB +: DIV_FW] == {DIV_FW{1'b1}})
            |=> (ratio_bad && ratio_rb == '0));
      end
   endgenerate

   // R6
   edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ref_tick) |=> $stable(clk_out));

   // R7
   rise_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> (!$past(sh_gate) && !$past(ratio_bad)));

   // R7
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sh_gate || ratio_bad) && !clk_out) |=> !clk_out);

   // R3
   ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_rb <= RATIO_W'(DIV_MAX * DIV_MAX));
endmodule

bind pclk_gen pclk_gen_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REF(NUM_REF), .RATIO_W(RATIO_W),
   .DIV_FW(DIV_FW), .DIV_MAX(DIV_MAX), .DIV_OFS(DIV_OFS),
   .DIV_A_LSB(DIV_A_LSB), .HAS_DIV(HAS_DIV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out),
   .ratio_rb(ratio_rb), .ratio_bad(ratio_bad), .sh_gate(gate_q)
);

// File: tb/sim_pclk_gen.sv
`timescale 1ns/1ps
module sim_pclk_gen;
   import pclk_gen_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ref_tick = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        clk_out0, clk_out1, bad0, bad1;
   logic [5:0]  rb0, rb1;

   always #5 clk = ~clk;

   pclk_gen u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out0),
      .ratio_rb(rb0), .ratio_bad(bad0)
   );

   pclk_gen #(.VARIANT(PG_TBL_2_4)) u1 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out1),
      .ratio_rb(rb1), .ratio_bad(bad1)
   );

   // reference tick spacing in system cycles, per source
   localparam int TPER [4] = '{2, 3, 4, 5};
   // stage A, stage B, source, ratio, high ticks, low ticks
   localparam int NV = 8;
   localparam int VEC [NV][6] = '{
      '{1, 1, 0,  1,  1,  1},
      '{2, 1, 1,  2,  1,  1},
      '{3, 1, 2,  3,  1,  2},
      '{5, 1, 0,  5,  2,  3},
      '{2, 3, 3,  6,  3,  3},
      '{3, 3, 1,  9,  4,  5},
      '{6, 6, 0, 36, 18, 18},
      '{4, 5, 2, 20, 10, 10}
   };

   int checks = 0, fails = 0;
   int cyc = 0, tc = 0, tc_rise = 0, tc_fall = 0;
   int n_rise = 0, n_fall = 0, last_hi = 0, last_lo = 0, offtick = 0;
   int mon_src = 0;
   logic prev_out = 1'b0;

   // monitor and tick generator: ticks change at negedge, stay stable across posedge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (ref_tick[mon_src]) tc = tc + 1;
         if (clk_out0 !== prev_out) begin
            if (!(|ref_tick)) offtick = offtick + 1;
            if (clk_out0) begin
               n_rise = n_rise + 1; last_lo = tc - tc_fall; tc_rise = tc;
            end else begin
               n_fall = n_fall + 1; last_hi = tc - tc_rise; tc_fall = tc;
            end
         end
         prev_out = clk_out0;
      end
      for (int i = 0; i < 4; i++) ref_tick[i] = ((cyc % TPER[i]) == 0);
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(); wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(); wr_en = 1'b0;
   endtask

   task automatic measure(input string tag, input int ehi, input int elo);
      int r0 = n_rise;
      int k = 0;
      while (n_rise < r0 + 3 && k < 6000) begin step(); k++; end
      if (k >= 6000) check({tag, " timeout"}, 0, 1);
      else begin
         check({tag, " high ticks"}, last_hi, ehi);
         check({tag, " low ticks"}, last_lo, elo);
      end
   endtask

   task automatic wait_rise();
      int r0 = n_rise;
      int k = 0;
      while (n_rise == r0 && k < 6000) begin step(); k++; end
   endtask

   task automatic wait_fall();
      int f0 = n_fall;
      int k = 0;
      while (n_fall == f0 && k < 6000) begin step(); k++; end
   endtask

   initial begin
      #1000000;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int r;
      repeat (5) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 clk_out after reset", clk_out0, 0);
      check("R1 ratio_rb after reset", rb0, 1);
      check("R1 ratio_bad after reset", bad0, 0);
      repeat (50) step();
      check("R1 stopped until stop bit cleared", n_rise, 0);

      wr(8'h14, 32'h0);
      // R3 R5 R6 vector table
      for (int i = 0; i < NV; i++) begin
         mon_src = VEC[i][2];
         wr(8'h04, 32'((VEC[i][0] << 3) | VEC[i][1]));
         wr(8'h00, 32'(VEC[i][2]));
         check($sformatf("R3 vector %0d ratio_rb", i), rb0, VEC[i][3]);
         measure($sformatf("R5 R6 vector %0d", i), VEC[i][4], VEC[i][5]);
      end

      // R2 writes to unused offsets are ignored
      wr(8'h08, 32'h3F);
      wr(8'h0C, 32'h0);
      wr(8'h10, 32'hFFFF_FFFF);
      check("R2 ratio_rb after foreign writes", rb0, 20);
      check("R2 status after foreign writes", bad0, 0);
      measure("R2 output after foreign writes", 10, 10);

      // R8 change during a period takes effect after it
      mon_src = 0;
      wr(8'h04, 32'h36);
      wr(8'h00, 32'h0);
      measure("R8 ratio 36", 18, 18);
      wait_rise();
      wr(8'h04, 32'h0A);
      wait_fall();
      check("R8 old high phase kept", last_hi, 18);
      wait_rise();
      check("R8 old low phase kept", last_lo, 18);
      measure("R8 new ratio 2", 1, 1);

      // R7 stop bit
      wr(8'h04, 32'h12);
      measure("R7 ratio 4 before stop", 2, 2);
      wait_rise();
      wr(8'h14, 32'h1);
      wait_fall();
      check("R7 high phase completes", last_hi, 2);
      repeat (20) step();
      r = n_rise;
      repeat (200) step();
      check("R7 no edge while stopped", n_rise, r);
      check("R7 output low while stopped", clk_out0, 0);
      wr(8'h14, 32'h0);
      measure("R7 restart", 2, 2);

      // R4 invalid divide fields
      wr(8'h04, 32'h3A);
      check("R4 field 7 ratio_rb", rb0, 0);
      check("R4 field 7 status", bad0, 1);
      repeat (300) step();
      r = n_rise;
      repeat (200) step();
      check("R4 no edge with invalid ratio", n_rise, r);
      check("R4 output low with invalid ratio", clk_out0, 0);
      wr(8'h04, 32'h03);
      check("R4 field 0 ratio_rb", rb0, 0);
      check("R4 field 0 status", bad0, 1);
      wr(8'h04, 32'h1A);
      check("R4 recovery status", bad0, 0);
      check("R3 recovery ratio_rb", rb0, 6);
      measure("R4 recovery output", 3, 3);

      // R9 lookup variant
      wr(8'h04, 32'h00);
      check("R9 code 0", rb1, 2);
      wr(8'h04, 32'h08);
      check("R9 code 1", rb1, 4);
      check("R9 code 1 status", bad1, 0);
      wr(8'h04, 32'h38);
      check("R9 code 7", rb1, 0);
      check("R9 code 7 status", bad1, 1);

      check("R6 edges only on tick cycles", offtick, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule